// File: doc/BRIEF.md
# Sequential Round-Subkey Generator

This block supplies the 16-bit subkeys of an eight-round, 64-bit Feistel cipher one at a time, on request from the cipher datapath. The 128-bit secret key is split into eight 16-bit words. A second set of eight 16-bit words is derived from them by a small nonlinear mixing function: each derived word is the first word mixed under the control of the word that follows it, wrapping round after the eighth. The derived set is never stored. Each word is recomputed when the datapath asks for it, so the only key-related state is a 16-bit intermediate register and the 16-bit output register.

Each request carries a round number and a selector. The selector names one of nine subkey roles: four output-mixing words, three inner-mixing words and two linear-layer words. A fixed map with modular index arithmetic turns the pair into one word index and a flag that says whether the plain or the derived word is wanted. A plain word returns one cycle after acceptance. A derived word runs the mixing function in two passes of one shared substitution stage and returns after two cycles. During the second pass the block refuses new requests.

Top module: `keygen_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `sub_valid` is 0, `req_ready` is 1 and `subkey` is 0.
- R2: Plain word Kj (j = 1..8) is `key_i[143-16j : 128-16j]`, so K1 is bits 127:112 and K8 is bits 15:0.
- R3: The mixing function FI(x,k) sets h = x[15:7] and l = x[6:0]. It applies a step (h = S9(h) xor {00,l}, then l = S7(l) xor h[6:0]), then h ^= k[8:0] and l ^= k[15:9], then the step once more, and returns {h,l}. S9(v) = v^5 over GF(2^9) modulo x^9+x^4+1, xor 9'h1A3. S7(v) = v^3 over GF(2^7) modulo x^7+x+1, xor 7'h2D.
- R4: Derived word Dj = FI(Kj, K(j mod 8 + 1)).
- R5: Round i (i = 1..8) is encoded as `round_i` = i-1. Selectors 0..3 return K(i), K(i+2), K(i+7) and K(i+4).
- R6: Selectors 4..6 return D(i+5), D(i+1) and D(i+3).
- R7: Selector 7 returns K((i+1)/2) for odd i and D(i/2+2) for even i. Selector 8 returns D((i+1)/2+6) for odd i and K(i/2+4) for even i. Every index above 8 wraps to the index minus 8.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. A plain-word request raises `sub_valid` for one cycle after the next edge with `req_ready` kept at 1. A derived-word request holds `req_ready` at 0 for one cycle and raises `sub_valid` one edge later.
- R9: A request presented while `req_ready` is 0 is not accepted and produces no output pulse.
- R10: Selector codes 9..15 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 128 | Secret key, held stable while a request is being served |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| round_i | input | 3 | Round number minus one |
| sel_i | input | 4 | Subkey role selector |
| sub_valid | output | 1 | One-cycle pulse: `subkey` holds the answer |
| subkey | output | 16 | Requested 16-bit subkey |

## Verification
Every round is swept against all nine selectors. This separates the four plain offsets from the three derived ones and shows up any mix-up between odd and even rounds in the linear-layer map. Two unrelated keys are used, one of them with distinct low bits in every word, so a wrong slice boundary, a wrong neighbour in the derived word or an S-box fault changes the expected value. Latency is checked for each kind of request. A request held across the busy cycle shows that nothing is accepted twice. Selectors 9 to 15 are compared against selector 0.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  localparam int SW    = 16;
  localparam int HW    = 9;
  localparam int LW    = 7;
  localparam int NWORD = 8;
  localparam int IW    = $clog2(NWORD);
  localparam int KEYW  = SW * NWORD;
  localparam int SELW  = 4;

  typedef enum logic [SELW-1:0] {
    SEL_O1 = 4'd0, SEL_O2 = 4'd1, SEL_O3 = 4'd2, SEL_O4 = 4'd3,
    SEL_I1 = 4'd4, SEL_I2 = 4'd5, SEL_I3 = 4'd6,
    SEL_L1 = 4'd7, SEL_L2 = 4'd8
  } sel_e;

  function automatic logic [HW-1:0] mul9(input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [HW-1:0] p;
    logic [HW-1:0] x;
    p = '0;
    x = a;
    for (int n = 0; n < HW; n++) begin
      if (b[n]) p = p ^ x;
      x = x[HW-1] ? ((x << 1) ^ 9'h011) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [LW-1:0] mul7(input logic [LW-1:0] a, input logic [LW-1:0] b);
    logic [LW-1:0] p;
    logic [LW-1:0] x;
    p = '0;
    x = a;
    for (int n = 0; n < LW; n++) begin
      if (b[n]) p = p ^ x;
      x = x[LW-1] ? ((x << 1) ^ 7'h03) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [HW-1:0] sub9(input logic [HW-1:0] v);
    logic [HW-1:0] sq;
    sq = mul9(v, v);
    return mul9(v, mul9(sq, sq)) ^ 9'h1A3;
  endfunction

  function automatic logic [LW-1:0] sub7(input logic [LW-1:0] v);
    return mul7(v, mul7(v, v)) ^ 7'h2D;
  endfunction
endpackage

// File: rtl/keygen_map.sv
module keygen_map
  import keygen_pkg::*;
(
  input  logic [IW-1:0]   round_i,
  input  logic [SELW-1:0] sel_i,
  output logic [IW-1:0]   idx_o,
  output logic            derived_o
);
  logic [IW-1:0] half;
  assign half = round_i >> 1;

  always_comb begin
    derived_o = 1'b0;
    idx_o     = round_i;
    case (sel_i)
      SEL_O2: idx_o = round_i + IW'(2);
      SEL_O3: idx_o = round_i + IW'(7);
      SEL_O4: idx_o = round_i + IW'(4);
      SEL_I1: begin idx_o = round_i + IW'(5); derived_o = 1'b1; end
      SEL_I2: begin idx_o = round_i + IW'(1); derived_o = 1'b1; end
      SEL_I3: begin idx_o = round_i + IW'(3); derived_o = 1'b1; end
      SEL_L1: begin
        if (!round_i[0]) idx_o = half;
        else begin idx_o = half + IW'(2); derived_o = 1'b1; end
      end
      SEL_L2: begin
        if (!round_i[0]) begin idx_o = half + IW'(6); derived_o = 1'b1; end
        else idx_o = half + IW'(4);
      end
      default: idx_o = round_i;
    endcase
  end
endmodule

// File: rtl/keygen_slice.sv
module keygen_slice
  import keygen_pkg::*;
(
  input  logic [KEYW-1:0] key_i,
  input  logic [IW-1:0]   idx_i,
  output logic [SW-1:0]   word_o,
  output logic [SW-1:0]   next_o
);
  logic [SW-1:0] words [NWORD];
  logic [IW-1:0] nidx;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    assign words[g] = key_i[KEYW-1-g*SW -: SW];
  end

  assign nidx   = idx_i + IW'(1);
  assign word_o = words[idx_i];
  assign next_o = words[nidx];
endmodule

// File: rtl/keygen_fi_half.sv
module keygen_fi_half
  import keygen_pkg::*;
(
  input  logic [SW-1:0] x_i,
  input  logic [SW-1:0] k_i,
  output logic [SW-1:0] y_o
);
  logic [HW-1:0] h1;
  logic [LW-1:0] l1;

  assign h1  = sub9(x_i[SW-1:LW]) ^ {{(HW-LW){1'b0}}, x_i[LW-1:0]};
  assign l1  = sub7(x_i[LW-1:0]) ^ h1[LW-1:0];
  assign y_o = {h1 ^ k_i[HW-1:0], l1 ^ k_i[SW-1:HW]};
endmodule

// File: rtl/keygen_top.sv
module keygen_top
  import keygen_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [127:0]    key_i,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      round_i,
  input  logic [3:0]      sel_i,
  output logic            sub_valid,
  output logic [15:0]     subkey
);
  logic [IW-1:0] idx;
  logic          derived;
  logic [SW-1:0] word, nword, mix_in, mix_key, mix_out;
  logic [SW-1:0] stage_q, out_q;
  logic          busy_q, vld_q, accept;

  keygen_map u_map (.round_i(round_i), .sel_i(sel_i), .idx_o(idx), .derived_o(derived));
  keygen_slice u_slice (.key_i(key_i), .idx_i(idx), .word_o(word), .next_o(nword));

  // one shared substitution stage: first pass keyed, second pass unkeyed
  assign mix_in  = busy_q ? stage_q : word;
  assign mix_key = busy_q ? '0 : nword;
  keygen_fi_half u_half (.x_i(mix_in), .k_i(mix_key), .y_o(mix_out));

  assign accept = req_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      vld_q   <= 1'b0;
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (busy_q) begin
        out_q  <= mix_out;
        vld_q  <= 1'b1;
        busy_q <= 1'b0;
      end else if (accept) begin
        if (derived) begin
          stage_q <= mix_out;
          busy_q  <= 1'b1;
        end else begin
          out_q <= word;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign sub_valid = vld_q;
  assign subkey    = out_q;
endmodule

// File: rtl/keygen_chk.sv
module keygen_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] sel_i,
  input logic       sub_valid
);
  // R8
  busy_short_chk: assert property (@(posedge clk) disable iff (rst) !req_ready |=> req_ready);
  // R8
  busy_result_chk: assert property (@(posedge clk) disable iff (rst) !req_ready |=> sub_valid);
  // R6
  derived_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && sel_i >= 4'd4 && sel_i <= 4'd6) |=> (!req_ready && !sub_valid));
  // R5
  plain_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && sel_i <= 4'd3) |=> (sub_valid && req_ready));
  // R9
  no_stray_chk: assert property (@(posedge clk) disable iff (rst)
    sub_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));
endmodule

bind keygen_top keygen_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .sel_i(sel_i), .sub_valid(sub_valid)
);

// File: tb/sim_keygen_top.sv
module sim_keygen_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] key_i = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   round_i = '0;
  logic [3:0]   sel_i = '0;
  logic         sub_valid;
  logic [15:0]  subkey;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keygen_top u0 (.clk(clk), .rst(rst), .key_i(key_i), .req_valid(req_valid),
    .req_ready(req_ready), .round_i(round_i), .sel_i(sel_i),
    .sub_valid(sub_valid), .subkey(subkey));

  // ---------- reference model from the requirements ----------
  function automatic int gmul(int a, int b, int w, int poly);
    int p = 0;
    int x = a;
    for (int n = 0; n < w; n++) begin
      if ((b >> n) & 1) p = p ^ x;
      x = x << 1;
      if ((x >> w) & 1) x = x ^ ((1 << w) | poly);
    end
    return p;
  endfunction
  function automatic int s9m(int v);
    int v4 = gmul(gmul(v, v, 9, 'h11), gmul(v, v, 9, 'h11), 9, 'h11);
    return gmul(v4, v, 9, 'h11) ^ 'h1A3;
  endfunction
  function automatic int s7m(int v);
    return gmul(gmul(v, v, 7, 3), v, 7, 3) ^ 'h2D;
  endfunction
  function automatic int fim(int x, int k);
    int h = (x >> 7) & 'h1FF;
    int l = x & 'h7F;
    h = s9m(h) ^ l;           l = s7m(l) ^ (h & 'h7F);
    h = h ^ (k & 'h1FF);      l = l ^ ((k >> 9) & 'h7F);
    h = s9m(h) ^ l;           l = s7m(l) ^ (h & 'h7F);
    return (h << 7) | l;
  endfunction
  function automatic int wr(int n);
    return (n > 8) ? n - 8 : n;
  endfunction
  function automatic int kw(logic [127:0] key, int j);
    return int'(key[143-16*j -: 16]);
  endfunction
  function automatic int dw(logic [127:0] key, int j);
    return fim(kw(key, j), kw(key, (j % 8) + 1));
  endfunction
  function automatic int expect_sub(logic [127:0] key, int i, int s);
    case (s)
      1: return kw(key, wr(i + 2));
      2: return kw(key, wr(i + 7));
      3: return kw(key, wr(i + 4));
      4: return dw(key, wr(i + 5));
      5: return dw(key, wr(i + 1));
      6: return dw(key, wr(i + 3));
      7: return (i % 2) ? kw(key, (i + 1) / 2) : dw(key, wr(i / 2 + 2));
      8: return (i % 2) ? dw(key, wr((i + 1) / 2 + 6)) : kw(key, wr(i / 2 + 4));
      default: return kw(key, i);
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request: returns value and latency in edges (0 = never)
  task automatic req(int r, int s, output int val, output int lat);
    @(negedge clk);
    req_valid = 1'b1; round_i = 3'(r - 1); sel_i = 4'(s);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; val = int'(subkey);
    if (sub_valid) lat = 1;
    else begin
      @(negedge clk);
      val = int'(subkey);
      if (sub_valid) lat = 2;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sub_valid == 0 && req_ready == 1 && subkey == 0, "R1 reset", int'(subkey), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sub_valid == 0 && req_ready == 1 && subkey == 0, "R1 after reset", int'(subkey), 0);
  endtask

  task automatic t_sweep(string tag);
    int v, l, e;
    for (int i = 1; i <= 8; i++) begin
      for (int s = 0; s <= 8; s++) begin
        req(i, s, v, l);
        e = expect_sub(key_i, i, s);
        if (s <= 3)      chk(v == e, {tag, " R2 R5 plain"}, v, e);
        else if (s <= 6) chk(v == e, {tag, " R3 R4 R6 derived"}, v, e);
        else             chk(v == e, {tag, " R7 linear"}, v, e);
      end
    end
  endtask

  task automatic t_latency;
    int v, l;
    req(3, 2, v, l);
    chk(l == 1, "R8 plain latency", l, 1);
    req(3, 5, v, l);
    chk(l == 2, "R8 derived latency", l, 2);
    // ready low during the busy cycle
    @(negedge clk);
    req_valid = 1'b1; round_i = 3'd0; sel_i = 4'd4;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 0 && sub_valid == 0, "R8 busy ready low", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == 1 && sub_valid == 1, "R8 ready back", int'(req_ready), 1);
    @(negedge clk);
    chk(sub_valid == 0, "R8 single pulse", int'(sub_valid), 0);
  endtask

  task automatic t_busy_ignore;
    int e = expect_sub(key_i, 2, 6);
    @(negedge clk);
    req_valid = 1'b1; round_i = 3'd1; sel_i = 4'd6;
    @(negedge clk);
    sel_i = 4'd0;                // held while ready is low
    @(negedge clk);
    req_valid = 1'b0;
    chk(sub_valid == 1 && int'(subkey) == e, "R9 derived value kept", int'(subkey), e);
    @(negedge clk);
    chk(sub_valid == 0, "R9 held request not taken", int'(sub_valid), 0);
  endtask

  task automatic t_alias;
    int v, l, e;
    for (int s = 9; s <= 15; s++) begin
      req(5, s, v, l);
      e = expect_sub(key_i, 5, 0);
      chk(v == e && l == 1, "R10 alias code", v, e);
    end
  endtask

  initial begin
    key_i = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    t_reset();
    t_sweep("keyA");
    t_latency();
    t_busy_ignore();
    t_alias();
    key_i = 128'h1A01_2B02_3C03_4D04_5E05_6F06_7008_8107;
    t_sweep("keyB");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule